// File: doc/BRIEF.md
# Constant Off-Time Bridge Current Limiter

This block guards one H-bridge. Each clock it compares a digitised load-current code against a limit threshold. Once the current reaches that threshold it requests that both bridge outputs go high-impedance. The request holds for a fixed number of microsecond ticks and then releases, so the driver switches the outputs back on. The result is a chopping regulator with a constant off time. During the off time no second limit event is accepted.

A second path watches two hard-short comparator flags, one for the high-side switches and one for the low-side switches. Every output-activation strobe opens a blanking window, so turn-on transients cannot trip this path. Outside that window, an asserted short flag raises a latch-off request on the next clock.

A third path takes a signed junction-temperature code in degrees Celsius. From it the block derives the limit threshold, in 0.1 A steps. The threshold stays at its nominal value up to a knee temperature. Above the knee it folds back linearly, using a fixed-point slope, until it reaches a floor at the trip temperature. Above the trip temperature the block raises an overtemperature request. The analog sensing and the bridge latch itself are outside the block.

Top module: `chop_limiter`

## Requirements
- R1: While `rst_n` is low and at the first clock after reset, `tri_req`, `short_req` and `ovt_trip` are 0 and `thr_code` holds `NOM_LIM` (65, i.e. 6.5 A).
- R2: `thr_code` is registered. One clock after `temp_code` is applied, it equals `NOM_LIM` for any temperature at or below `KNEE_C` (160), including negative codes.
- R3: For `KNEE_C` < T <= `TRIP_C`, `thr_code` equals `NOM_LIM` minus the drop rounded to the nearest integer. The drop is (`NOM_LIM`-`FLOOR_LIM`)*(T-`KNEE_C`)/(`TRIP_C`-`KNEE_C`). The result is 25 at 175 °C and 44 at 168 °C.
- R4: For T > `TRIP_C` (175), `thr_code` equals `FLOOR_LIM` (25) and `ovt_trip` is 1 one clock later. At T = 175, `ovt_trip` is 0.
- R5: When `tri_req` is 0 and `cur_code` >= `thr_code` at a clock edge, `tri_req` is 1 after that edge. This applies at the nominal threshold and at a folded-back one.
- R6: `tri_req` stays high until the `OFF_US`-th `us_tick` counted after the edge that set it (default 20). It falls at that edge, so it never falls at an edge without `us_tick`.
- R7: A limit condition present while `tri_req` is high neither extends nor restarts the off time. After release, a limit still present sets `tri_req` again at the next edge.
- R8: A short flag sampled in the same cycle as `act_stb`, or during the following `BLANK_US` ticks (default 16), does not raise `short_req`.
- R9: Outside blanking, `short_hi` or `short_lo` high at an edge makes `short_req` 1 after that edge. `short_req` returns to 0 one edge after both flags are low.
- R10: An `act_stb` arriving while blanking is active restarts the blanking window with the full `BLANK_US` ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| act_stb | input | 1 | One-cycle strobe at each output activation |
| cur_code | input | CUR_W | Measured load current, 0.1 A per LSB |
| short_hi | input | 1 | High-side hard-short comparator flag |
| short_lo | input | 1 | Low-side hard-short comparator flag |
| temp_code | input | TEMP_W | Signed junction temperature, 1 °C per LSB |
| tri_req | output | 1 | Off-time request: both bridge outputs high-impedance |
| short_req | output | 1 | Latch-off request from an unblanked hard short |
| ovt_trip | output | 1 | Overtemperature latch-off request |
| thr_code | output | CUR_W | Present limit threshold, 0.1 A per LSB |

## Verification
Two events can fall on the same edge: an activation strobe and an asserted short flag. The block must treat that short as blanked. The bench provokes this directly by raising `act_stb` together with `short_hi`, and then holds the flag through the blanking window. It judges the result by the absence of `short_req` until the last blanking tick, followed by its appearance one edge later. The same pattern is repeated with a second strobe in mid-window, which shows that the window restarts. A cycle-accurate behavioural model separately places a limit event on the release edge of the off time, and every clock the bench compares the model against all four outputs.

// File: rtl/chop_pkg.sv
package chop_pkg;
   // width needed to hold values 0..n inclusive, never below one bit
   function automatic int cnt_bits(input int n);
      int w;
      w = $clog2(n + 1);
      return (w < 1) ? 1 : w;
   endfunction

   // rounded fixed-point slope: drop per degree, scaled by 2**frac
   function automatic int slope_q(input int drop, input int span, input int frac);
      return (2 * drop * (1 << frac) + span) / (2 * span);
   endfunction
endpackage

// File: rtl/us_timer.sv
module us_timer #(
   parameter int DUR = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   output logic busy
);
   import chop_pkg::*;
   localparam int CNT_W = cnt_bits(DUR);

   if (DUR < 1) begin : g_bad_dur
      $error("us_timer: DUR must be at least 1");
   end

   if (DUR == 1) begin : g_single
      logic run_q;
      always_ff @(posedge clk) begin
         if (!rst_n)     run_q <= 1'b0;
         else if (start) run_q <= 1'b1;
         else if (tick)  run_q <= 1'b0;
      end
      assign busy = run_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                    cnt_q <= '0;
         else if (start)                cnt_q <= CNT_W'(DUR);
         else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
      assign busy = (cnt_q != '0);
   end

   AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);                                            // R10
   AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> busy);                                  // R6
endmodule

// File: rtl/thr_foldback.sv
module thr_foldback #(
   parameter int CUR_W     = 8,
   parameter int TEMP_W    = 9,
   parameter int NOM_LIM   = 65,
   parameter int FLOOR_LIM = 25,
   parameter int KNEE_C    = 160,
   parameter int TRIP_C    = 175,
   parameter int FRAC      = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [TEMP_W-1:0] temp_code,
   output logic [CUR_W-1:0]         thr_q,
   output logic                     trip_q
);
   import chop_pkg::*;
   localparam int SPAN    = TRIP_C - KNEE_C;
   localparam int DROP    = NOM_LIM - FLOOR_LIM;
   localparam int SLOPE_Q = slope_q(DROP, SPAN, FRAC);

   if (SPAN < 1) begin : g_bad_span
      $error("thr_foldback: TRIP_C must exceed KNEE_C");
   end
   if (DROP < 0) begin : g_bad_drop
      $error("thr_foldback: FLOOR_LIM must not exceed NOM_LIM");
   end
   if (FRAC < 0 || FRAC > 16) begin : g_bad_frac
      $error("thr_foldback: FRAC out of range 0..16");
   end

   logic [31:0] half;
   if (FRAC > 0) begin : g_round
      assign half = 32'(1) << (FRAC - 1);
   end else begin : g_trunc
      assign half = '0;
   end

   logic signed [31:0] t_ext;
   logic [31:0]        dt, drop_r;
   logic [CUR_W-1:0]   thr_n;
   logic               trip_n;

   always_comb begin
      t_ext  = 32'(temp_code);
      dt     = 32'(t_ext - KNEE_C);
      drop_r = (dt * 32'(SLOPE_Q) + half) >> FRAC;
      trip_n = 1'b0;
      if (t_ext <= KNEE_C) begin
         thr_n = CUR_W'(NOM_LIM);
      end else if (t_ext > TRIP_C) begin
         thr_n  = CUR_W'(FLOOR_LIM);
         trip_n = 1'b1;
      end else begin
         thr_n = CUR_W'(32'(NOM_LIM) - drop_r);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q  <= CUR_W'(NOM_LIM);
         trip_q <= 1'b0;
      end else begin
         thr_q  <= thr_n;
         trip_q <= trip_n;
      end
   end

   AST_THR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q >= CUR_W'(FLOOR_LIM)) && (thr_q <= CUR_W'(NOM_LIM)));  // R3
   AST_TRIP_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(temp_code) > TRIP_C) |=> (trip_q && thr_q == CUR_W'(FLOOR_LIM))); // R4
endmodule

// File: rtl/chop_limiter.sv
module chop_limiter #(
   parameter int CUR_W     = 8,
   parameter int TEMP_W    = 9,
   parameter int OFF_US    = 20,
   parameter int BLANK_US  = 16,
   parameter int NOM_LIM   = 65,
   parameter int FLOOR_LIM = 25,
   parameter int KNEE_C    = 160,
   parameter int TRIP_C    = 175,
   parameter int FRAC      = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     us_tick,
   input  logic                     act_stb,
   input  logic [CUR_W-1:0]         cur_code,
   input  logic                     short_hi,
   input  logic                     short_lo,
   input  logic signed [TEMP_W-1:0] temp_code,
   output logic                     tri_req,
   output logic                     short_req,
   output logic                     ovt_trip,
   output logic [CUR_W-1:0]         thr_code
);
   if (NOM_LIM >= (1 << CUR_W)) begin : g_bad_nom
      $error("chop_limiter: NOM_LIM does not fit CUR_W");
   end
   if (TRIP_C >= (1 << (TEMP_W - 1))) begin : g_bad_trip
      $error("chop_limiter: TRIP_C does not fit signed TEMP_W");
   end

   // threshold and overtemperature
   thr_foldback #(
      .CUR_W(CUR_W), .TEMP_W(TEMP_W), .NOM_LIM(NOM_LIM), .FLOOR_LIM(FLOOR_LIM),
      .KNEE_C(KNEE_C), .TRIP_C(TRIP_C), .FRAC(FRAC)
   ) i_thr (
      .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
      .thr_q(thr_code), .trip_q(ovt_trip)
   );

   // constant off-time: a limit hit only arms the timer while it is idle
   logic off_busy, lim_hit;
   assign lim_hit = !off_busy && (cur_code >= thr_code);

   us_timer #(.DUR(OFF_US)) i_off (
      .clk(clk), .rst_n(rst_n), .start(lim_hit), .tick(us_tick), .busy(off_busy)
   );
   assign tri_req = off_busy;

   // blanking after each activation, restarted by every strobe
   logic blank_busy, blank_now, short_q;
   us_timer #(.DUR(BLANK_US)) i_blank (
      .clk(clk), .rst_n(rst_n), .start(act_stb), .tick(us_tick), .busy(blank_busy)
   );
   assign blank_now = act_stb || blank_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) short_q <= 1'b0;
      else        short_q <= (short_hi || short_lo) && !blank_now;
   end
   assign short_req = short_q;

   AST_LIMIT_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tri_req && cur_code >= thr_code) |=> tri_req);            // R5
   AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tri_req) |-> $past(us_tick));                         // R6
   AST_OFF_NO_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
      (tri_req && !us_tick) |=> tri_req);                         // R7
   AST_BLANK_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      act_stb |=> !short_req);                                    // R8
   AST_SHORT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      ((short_hi || short_lo) && !act_stb && !blank_busy) |=> short_req); // R9
endmodule

// File: tb/test_chop_limiter.sv
module test_chop_limiter;
   localparam int OFF   = 20;
   localparam int BLANK = 16;
   localparam int NOM   = 65;
   localparam int FLOOR = 25;
   localparam int KNEE  = 160;
   localparam int TRIP  = 175;
   localparam int TDIV  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 1'b0;
   logic act_stb = 1'b0;
   logic short_hi = 1'b0;
   logic short_lo = 1'b0;
   logic [7:0] cur_code = '0;
   logic signed [8:0] temp_code = 9'sd25;
   logic tri_req, short_req, ovt_trip;
   logic [7:0] thr_code;

   chop_limiter i_chop_limiter (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .act_stb(act_stb),
      .cur_code(cur_code), .short_hi(short_hi), .short_lo(short_lo),
      .temp_code(temp_code), .tri_req(tri_req), .short_req(short_req),
      .ovt_trip(ovt_trip), .thr_code(thr_code)
   );

   always #2 clk = ~clk;   // 250 MHz

   int n_chk = 0;
   int n_fail = 0;
   bit armed = 0;
   string phase = "R1";

   function automatic int ref_thr(input int t);
      if (t <= KNEE) return NOM;
      if (t > TRIP)  return FLOOR;
      return NOM - (2 * (NOM - FLOOR) * (t - KNEE) + (TRIP - KNEE)) / (2 * (TRIP - KNEE));
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // behavioural reference model, advanced on every rising edge
   int m_off, m_blank, m_thr;
   bit m_tri, m_short, m_ovt;
   always @(posedge clk) begin
      bit lim, bl;
      if (!rst_n) begin
         m_off = 0; m_blank = 0; m_thr = NOM;
         m_tri = 0; m_short = 0; m_ovt = 0;
      end else begin
         lim = (m_off == 0) && (int'(cur_code) >= m_thr);
         bl  = act_stb || (m_blank > 0);
         m_short = (short_hi || short_lo) && !bl;
         if (act_stb) m_blank = BLANK;
         else if (us_tick && m_blank > 0) m_blank--;
         if (m_off == 0) begin
            if (lim) m_off = OFF;
         end else if (us_tick) m_off--;
         m_tri = (m_off > 0);
         m_thr = ref_thr(int'(temp_code));
         m_ovt = int'(temp_code) > TRIP;
      end
   end

   always @(negedge clk) begin
      if (armed) begin
         n_chk++;
         if (tri_req !== m_tri || short_req !== m_short || ovt_trip !== m_ovt ||
             int'(thr_code) != m_thr) begin
            n_fail++;
            $display("FAIL %s cycle: tri %0b/%0b short %0b/%0b ovt %0b/%0b thr %0d/%0d (actual/expected)",
                     phase, tri_req, m_tri, short_req, m_short, ovt_trip, m_ovt,
                     thr_code, m_thr);
         end
      end
   end

   // microsecond tick generator
   initial begin
      int div = 0;
      forever begin
         @(negedge clk);
         div = (div + 1) % TDIV;
         us_tick = (div == 0);
      end
   end

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int d;
      step(5);
      armed = 1;
      // R1: reset state
      chk("R1 tri", tri_req, 0); chk("R1 short", short_req, 0);
      chk("R1 ovt", ovt_trip, 0); chk("R1 thr", thr_code, NOM);
      rst_n = 1'b1;
      step(1);
      chk("R1 after release", thr_code, NOM);

      phase = "R2";
      temp_code = -9'sd40; step(2); chk("R2 -40C", thr_code, 65);
      temp_code = 9'sd160; step(2); chk("R2 knee", thr_code, 65);

      phase = "R3";
      for (int t = 161; t <= 175; t++) begin
         temp_code = 9'(t); step(2); chk("R3 sweep", thr_code, ref_thr(t));
      end
      temp_code = 9'sd168; step(2); chk("R3 168C", thr_code, 44);
      temp_code = 9'sd175; step(2); chk("R3 175C", thr_code, 25);
      chk("R4 no trip at 175", ovt_trip, 0);

      phase = "R4";
      temp_code = 9'sd176; step(2);
      chk("R4 thr", thr_code, 25); chk("R4 trip", ovt_trip, 1);
      temp_code = 9'sd200; step(2); chk("R4 200C", ovt_trip, 1);
      temp_code = 9'sd25; step(2); chk("R4 cool", ovt_trip, 0);

      phase = "R5";
      cur_code = 8'd64; step(3); chk("R5 below", tri_req, 0);
      cur_code = 8'd65; step(1); chk("R5 engage", tri_req, 1);

      phase = "R6";
      d = 1;
      while (tri_req && d < 1000) begin step(1); if (tri_req) d++; end
      n_chk++;
      if (d < (OFF - 1) * TDIV + 1 || d > OFF * TDIV) begin
         n_fail++;
         $display("FAIL R6 off length: actual %0d expected %0d..%0d", d,
                  (OFF - 1) * TDIV + 1, OFF * TDIV);
      end
      phase = "R7";
      chk("R7 released", tri_req, 0);
      step(1); chk("R7 re-engage", tri_req, 1);
      cur_code = 8'd0;
      step(30); chk("R7 held mid off", tri_req, 1);
      while (tri_req) step(1);

      phase = "R5";
      temp_code = 9'sd170; step(2); chk("R5 fold thr", thr_code, 38);
      cur_code = 8'd38; step(1); chk("R5 folded engage", tri_req, 1);
      cur_code = 8'd0;
      while (tri_req) step(1);
      temp_code = 9'sd25; step(2);

      phase = "R8";
      act_stb = 1'b1; short_hi = 1'b1; step(1);
      act_stb = 1'b0;
      chk("R8 same cycle", short_req, 0);
      step(8 * TDIV); chk("R8 mid blank", short_req, 0);
      phase = "R9";
      step(9 * TDIV); chk("R9 after blank", short_req, 1);
      short_hi = 1'b0; step(1); chk("R9 drop", short_req, 0);

      phase = "R10";
      act_stb = 1'b1; step(1); act_stb = 1'b0;
      step(12 * TDIV);
      act_stb = 1'b1; cur_code = 8'd70; step(1); act_stb = 1'b0;
      step(10 * TDIV);
      short_lo = 1'b1; step(2); chk("R10 restarted blank", short_req, 0);
      cur_code = 8'd0;
      step(10 * TDIV); chk("R9 low side", short_req, 1);
      short_lo = 1'b0;
      while (tri_req) step(1);
      step(3);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule